// File: doc/BRIEF.md
# Accumulating Bit-Serial Adder

This block adds two N-bit binary numbers one bit pair per clock, using a single full adder and a carry flip-flop. The running total sits in an accumulator shift register and the addend sits in a second shift register. Both registers move right, so the least-significant bits meet the adder first. Each sum bit enters the accumulator at its most-significant end. After N shifting cycles the accumulator holds the whole N-bit sum in place, and the carry flip-flop holds the carry out of the top bit.

The addend register rotates instead of discarding bits, so it is back in its loaded state when an addition ends. Starting again adds the same value a second time. Loading a new addend and starting adds that value to the running total. Shifting is held back through register enables driven by an internal busy flag. The clock is never gated.

The block is used like this: clear the accumulator, load an addend, pulse start, and wait for done. Repeat the load and start steps to sum a list of values.

Top module: `bsa_accum`

## Requirements
- R1: While reset is high, and on the first cycle after it, `acc` is zero and `cout`, `busy` and `done` are low.
- R2: A `ld_b` pulse while `busy` is low captures `b_in` as the addend. The next addition uses that value.
- R3: If `start` is high while `busy` is low and `clr` is low, `busy` rises on the next cycle. It stays high for exactly WIDTH cycles. `done` is high for exactly one cycle, on the first cycle in which `busy` is low again.
- R4: When `done` is high, `acc` equals (previous `acc` + addend) mod 2^WIDTH, and `cout` equals bit WIDTH of that sum (1 = carry out of the top bit).
- R5: Successive additions accumulate: each one adds its addend to the `acc` value left by the previous one.
- R6: The addend register is unchanged by a completed addition, so starting again without a new load adds the same addend again.
- R7: A `clr` pulse sets `acc` to zero, `cout` low and `busy` low on the next cycle, even in the middle of an addition. That addition then produces no `done`.
- R8: A `ld_b` pulse while `busy` is high is ignored. The addition in progress, and later ones, keep using the previously loaded addend.
- R9: A `start` pulse while `busy` is high is ignored. The busy window keeps its WIDTH length and yields a single `done`.
- R10: The carry flip-flop is cleared when an addition starts, so a `cout` of 1 left by one addition does not feed into the next sum.
- R11: While `busy` is low and no `clr` is applied, `acc` does not change, even when `ld_b` is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of accumulator and carry; aborts a running addition |
| ld_b | input | 1 | Load the addend from `b_in` (only while idle) |
| b_in | input | WIDTH | Addend value |
| start | input | 1 | Begin one addition (only while idle) |
| busy | output | 1 | Addition in progress (shifting enabled) |
| done | output | 1 | One-cycle pulse when the sum is complete |
| cout | output | 1 | Carry flag; holds the final carry after done |
| acc | output | WIDTH | Accumulator (running sum) |

## Verification
Starting from zero, a small addend is added twice. This shows that the sum is built in place and that the addend survives the rotation. Addends that carry past the top bit (0x4A+0xF0, 0x3B+0xC5) and a carry that ripples through every bit (0xFF+0x01) exercise the saved carry and the carry-out flag. An addition that follows one with a carry out of 1 shows whether the carry flip-flop is cleared at start. Mid-run loads, mid-run starts and mid-run clears test the busy guards and the abort path. Idle addend loads check that the accumulator holds its value.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef struct packed {
    logic sum;
    logic carry;
  } fa_out_t;
endpackage

// File: rtl/bsa_fa.sv
module bsa_fa
  import bsa_pkg::*;
(
  input  logic    a,
  input  logic    b,
  input  logic    cin,
  output fa_out_t y
);
  always_comb begin
    y.sum   = a ^ b ^ cin;
    y.carry = (a & b) | (a & cin) | (b & cin);
  end
endmodule

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
  parameter int WIDTH    = 8,
  parameter bit LOADABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             sh,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nxt;

  generate
    if (LOADABLE) begin : g_load
      always_comb begin
        if (ld)      nxt = ld_val;
        else if (sh) nxt = {ser_in, q[WIDTH-1:1]};
        else         nxt = q;
      end
    end else begin : g_noload
      logic unused_ld;
      assign unused_ld = ld ^ (^ld_val);
      always_comb begin
        if (sh) nxt = {ser_in, q[WIDTH-1:1]};
        else    nxt = q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else            q <= nxt;
  end
endmodule

// File: rtl/bsa_seq.sv
module bsa_seq #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  output logic go,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] cnt;

  assign go = start & ~busy & ~clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bsa_accum.sv
module bsa_accum
  import bsa_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld_b,
  input  logic [WIDTH-1:0] b_in,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             cout,
  output logic [WIDTH-1:0] acc
);
  logic             go;
  logic             carry_q;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  fa_out_t          fa_y;

  bsa_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst(rst), .clr(clr), .start(start),
    .go(go), .busy(busy), .done(done)
  );

  bsa_fa u_fa (
    .a(a_q[0]), .b(b_q[0]), .cin(carry_q), .y(fa_y)
  );

  // accumulator: sum bit enters at the top
  bsa_shreg #(.WIDTH(WIDTH), .LOADABLE(1'b0)) u_areg (
    .clk(clk), .rst(rst), .clr(clr), .ld(1'b0), .ld_val('0),
    .sh(busy), .ser_in(fa_y.sum), .q(a_q)
  );

  // addend: rotates so it is intact after WIDTH shifts
  bsa_shreg #(.WIDTH(WIDTH), .LOADABLE(1'b1)) u_breg (
    .clk(clk), .rst(rst), .clr(1'b0), .ld(ld_b & ~busy), .ld_val(b_in),
    .sh(busy), .ser_in(b_q[0]), .q(b_q)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) carry_q <= 1'b0;
    else if (go)    carry_q <= 1'b0;
    else if (busy)  carry_q <= fa_y.carry;
  end

  assign acc  = a_q;
  assign cout = carry_q;
endmodule

// File: rtl/bsa_accum_chk.sv
module bsa_accum_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             ld_b,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             cout,
  input logic [WIDTH-1:0] acc
);
  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= 0;
    else              run_cnt <= run_cnt + 1;
  end

  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> (acc == '0 && !cout && !busy && !done)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !clr) |=> busy); // R3
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < WIDTH)); // R3
  AST_DONE_END: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R3
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0 && !cout && !busy && !done)); // R7
  AST_START_CARRY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !clr) |=> !cout); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !clr) |=> $stable(acc)); // R11
  AST_LDB_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ld_b && !busy && !clr && !start) |=> !busy); // R2
endmodule

bind bsa_accum bsa_accum_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .ld_b(ld_b), .start(start),
  .busy(busy), .done(done), .cout(cout), .acc(acc)
);

// File: tb/tb_bsa_accum.sv
module tb_bsa_accum;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, clr, ld_b, start;
  logic [W-1:0] b_in;
  logic         busy, done, cout;
  logic [W-1:0] acc;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] m_acc;
  logic [W-1:0] m_b;

  always #2 clk = ~clk;

  bsa_accum #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .clr(clr), .ld_b(ld_b), .b_in(b_in),
    .start(start), .busy(busy), .done(done), .cout(cout), .acc(acc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; clr = 0; ld_b = 0; start = 0; b_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 acc", acc, 0);
    chk("R1 flags", {busy, done, cout}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 acc after release", acc, 0);
    m_acc = '0; m_b = '0;
  endtask

  task automatic load_b(input logic [W-1:0] v);
    ld_b = 1; b_in = v;
    @(negedge clk);
    ld_b = 0; b_in = '0;
    m_b = v;
  endtask

  // one full addition with timing, sum and carry checks
  task automatic run_add(input string tag);
    logic [W:0] s;
    int n;
    s = {1'b0, m_acc} + {1'b0, m_b};
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk({tag, " R3 busy length"}, n, W);
    chk({tag, " R3 done"}, done, 1);
    chk({tag, " R4 acc"}, acc, s[W-1:0]);
    chk({tag, " R4 cout"}, cout, s[W]);
    @(negedge clk);
    chk({tag, " R3 done one cycle"}, done, 0);
    m_acc = s[W-1:0];
  endtask

  task automatic t_basic();
    load_b(8'h25);
    run_add("R2 first");
    run_add("R6 same addend");
    load_b(8'hF0);
    run_add("R5 accumulate carry");
    load_b(8'h01);
    run_add("R10 carry cleared");
    load_b(8'hC5);
    run_add("R4 wrap to zero");
    load_b(8'hFF);
    run_add("R5 all ones");
    load_b(8'h01);
    run_add("R4 full ripple");
  endtask

  task automatic t_idle();
    logic [W-1:0] hold;
    hold = acc;
    ld_b = 1; b_in = 8'h3C;
    @(negedge clk);
    ld_b = 0;
    repeat (4) @(negedge clk);
    chk("R11 acc held", acc, hold);
    chk("R11 busy stays low", busy, 0);
    m_b = 8'h3C;
    run_add("R2 idle load used");
  endtask

  task automatic t_ld_busy();
    logic [W:0] s;
    load_b(8'h11);
    s = {1'b0, m_acc} + 9'h011;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    ld_b = 1; b_in = 8'h77;
    @(negedge clk);
    ld_b = 0;
    while (!done) @(negedge clk);
    chk("R8 sum ignores busy load", acc, s[W-1:0]);
    m_acc = s[W-1:0];
    @(negedge clk);
    run_add("R8 addend kept");
  endtask

  task automatic t_start_busy();
    int dones, n;
    load_b(8'h09);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    dones = 0; n = 3;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R9 busy length", n, W);
    for (int i = 0; i < W + 4; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk("R9 one done", dones, 1);
    chk("R9 sum", acc, m_acc + m_b);
    m_acc = m_acc + m_b;
  endtask

  task automatic t_clr();
    int dones;
    clr = 1;
    @(negedge clk);
    clr = 0;
    chk("R7 idle clear acc", acc, 0);
    chk("R7 idle clear cout", cout, 0);
    m_acc = '0;
    load_b(8'hAB);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    chk("R7 abort busy", busy, 0);
    chk("R7 abort acc", acc, 0);
    dones = 0;
    for (int i = 0; i < W + 2; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk("R7 no done after abort", dones, 0);
    load_b(8'h5A);
    run_add("R7 after clear");
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_basic();
    t_idle();
    t_ld_busy();
    t_start_busy();
    t_clr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule